// File: doc/BRIEF.md
# Tiled Wide-Matrix Bit Transpose Sequencer

This block transposes a large square bit matrix held in word-organised memory, using narrow square transpose cores that each see one tile at a time. A row of the N x N matrix occupies N/W consecutive W-bit words. The matrix is cut into square W x W tiles. The sequencer reads one tile row per cycle and streams it into a core. It then writes each transposed W-bit slice to the place where it belongs in the output matrix.

Tiles are visited one column strip at a time. Every row-part of a strip is processed before the next strip starts. Each group of W output rows is therefore complete when its strip ends, and no full-matrix buffer is needed. A one-cycle start pulse latches the source and destination base addresses. A one-cycle done pulse marks the end of the last write.

The number of cores is a parameter. With several cores, core l takes the strips whose index is congruent to l modulo the core count, and all cores run in lockstep on their own read and write ports.

Top module: `tiled_transpose`

## Requirements
- R1: While reset is held, and after it is released, rd_en, wr_en and done are all low until a start is accepted.
- R2: After an accepted start in cycle S, each lane reads one word per cycle in cycles S+1 to S+T, where T = N*N/(W*CORES). For tile row j, row-part p and strip c, the address is src + j*(N/W) + p*W*(N/W) + c. The order is j fastest, then p, then the lane's strips in rising order. rd_data is expected one cycle after its address.
- R3: Input matrix bit (row r, column x) is bit x%W of word r*(N/W) + x/W. Output bit (row x, column r) is placed the same way. So data bit j of output word i of tile (p, c) equals input row p*W+j, column c*W+i.
- R4: Output word i of tile (p, c) is written at dst + p + c*W*(N/W) + i*(N/W). Every word of the N*N/W-word output region is written exactly once per run.
- R5: Each lane writes in a fixed order: word index i fastest, then row-part p, then its strips in rising order. All output rows of one strip are written before any word of the next strip.
- R6: The first write appears W+3 cycles after the start cycle. Writes only happen during a run, and the last write is in cycle S+T+W+2.
- R7: done is high for exactly one cycle, in the cycle after the last write.
- R8: A start pulse during a run is ignored. The run in progress keeps its addresses, order and timing.
- R9: src_base and dst_base are sampled only in the cycle a start is accepted. Later changes have no effect on the run.
- R10: With CORES lanes, lane l handles strips l, l+CORES, and so on. All lanes assert rd_en and wr_en in the same cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to transpose one matrix |
| src_base | input | AW | Word address of the first input word |
| dst_base | input | AW | Word address of the first output word |
| rd_en | output | CORES | Read strobe per lane |
| rd_addr | output | CORES*AW | Read word address per lane |
| rd_data | input | CORES*W | Read data per lane, one cycle after the address |
| wr_en | output | CORES | Write strobe per lane |
| wr_addr | output | CORES*AW | Write word address per lane |
| wr_data | output | CORES*W | Transposed word per lane |
| done | output | 1 | One-cycle pulse after the last write |

## Verification
The bench builds two instances with N=32, W=8 and AW=9: one with a single core and one with two cores. Each instance has 16 tiles and a 128-word matrix, so a run lasts under 150 cycles. At this size every read address, every written word and the cycle of each write and done can be checked against a bit-by-bit reference. The two-core build covers alternate-strip lane splitting. Non-zero and differing bases expose mistakes in the address terms that a zero base would hide.

// File: rtl/tt_pkg.sv
`timescale 1ns/1ps
package tt_pkg;
   // Width of a counter that must hold values 0 .. n-1 (never zero).
   function automatic int unsigned cnt_w(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/tt_rd_seq.sv
`timescale 1ns/1ps
module tt_rd_seq
   import tt_pkg::*;
#(
   parameter int unsigned W     = 64,
   parameter int unsigned R     = 16,
   parameter int unsigned SPL   = 16,
   parameter int unsigned LANE  = 0,
   parameter int unsigned CORES = 1,
   parameter int unsigned AW    = 20
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic [AW-1:0] base,
   output logic          rd_en,
   output logic [AW-1:0] rd_addr,
   output logic          row_last
);
   localparam int unsigned JW = cnt_w(W);
   localparam int unsigned PW = cnt_w(R);
   localparam int unsigned SW = cnt_w(SPL);

   logic          run;
   logic [JW-1:0] j_q;
   logic [PW-1:0] p_q;
   logic [SW-1:0] s_q;
   logic [AW-1:0] base_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run    <= 1'b0;
         j_q    <= '0;
         p_q    <= '0;
         s_q    <= '0;
         base_q <= '0;
      end else if (go) begin
         run    <= 1'b1;
         j_q    <= '0;
         p_q    <= '0;
         s_q    <= '0;
         base_q <= base;
      end else if (run) begin
         if (j_q == JW'(W-1)) begin
            j_q <= '0;
            if (p_q == PW'(R-1)) begin
               p_q <= '0;
               if (s_q == SW'(SPL-1)) run <= 1'b0;
               else                   s_q <= s_q + 1'b1;
            end else begin
               p_q <= p_q + 1'b1;
            end
         end else begin
            j_q <= j_q + 1'b1;
         end
      end
   end

   assign rd_en    = run;
   assign row_last = run && (j_q == JW'(W-1));
   assign rd_addr  = base_q + AW'(j_q) * AW'(R) + AW'(p_q) * AW'(W*R)
                   + AW'(s_q) * AW'(CORES) + AW'(LANE);
endmodule

// File: rtl/tt_core.sv
`timescale 1ns/1ps
module tt_core
   import tt_pkg::*;
#(
   parameter int unsigned W = 64
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  logic [W-1:0] in_data,
   input  logic         in_last,
   output logic         out_valid,
   output logic [W-1:0] out_data
);
   localparam int unsigned OW = cnt_w(W);

   // acc[k] gathers input bit k of each tile row; row j lands in bit j.
   logic [W-1:0][W-1:0] acc;
   logic [W-1:0][W-1:0] bank;
   logic [OW-1:0]       ocnt;
   logic                ovalid;

   always_ff @(posedge clk) begin
      if (in_valid) begin
         for (int k = 0; k < int'(W); k++)
            acc[k] <= {in_data[k], acc[k][W-1:1]};
      end
   end

   always_ff @(posedge clk) begin
      if (in_valid && in_last) begin
         for (int k = 0; k < int'(W); k++)
            bank[k] <= {in_data[k], acc[k][W-1:1]};
      end else if (ovalid) begin
         for (int k = 0; k < int'(W) - 1; k++)
            bank[k] <= bank[k+1];
         bank[W-1] <= '0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ovalid <= 1'b0;
         ocnt   <= '0;
      end else if (in_valid && in_last) begin
         ovalid <= 1'b1;
         ocnt   <= '0;
      end else if (ovalid) begin
         ocnt <= ocnt + 1'b1;
         if (ocnt == OW'(W-1)) ovalid <= 1'b0;
      end
   end

   assign out_valid = ovalid;
   assign out_data  = bank[0];
endmodule

// File: rtl/tt_wr_seq.sv
`timescale 1ns/1ps
module tt_wr_seq
   import tt_pkg::*;
#(
   parameter int unsigned W     = 64,
   parameter int unsigned R     = 16,
   parameter int unsigned SPL   = 16,
   parameter int unsigned LANE  = 0,
   parameter int unsigned CORES = 1,
   parameter int unsigned AW    = 20
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic [AW-1:0] base,
   input  logic          out_valid,
   input  logic [W-1:0]  out_data,
   output logic          wr_en,
   output logic [AW-1:0] wr_addr,
   output logic [W-1:0]  wr_data,
   output logic          wr_fin
);
   localparam int unsigned IW = cnt_w(W);
   localparam int unsigned PW = cnt_w(R);
   localparam int unsigned SW = cnt_w(SPL);

   logic [IW-1:0] i_q;
   logic [PW-1:0] p_q;
   logic [SW-1:0] s_q;
   logic [AW-1:0] base_q;
   logic [AW-1:0] addr_c;
   logic          end_c;

   assign addr_c = base_q + AW'(p_q)
                 + (AW'(s_q) * AW'(CORES) + AW'(LANE)) * AW'(W*R)
                 + AW'(i_q) * AW'(R);
   assign end_c  = (i_q == IW'(W-1)) && (p_q == PW'(R-1)) && (s_q == SW'(SPL-1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         i_q    <= '0;
         p_q    <= '0;
         s_q    <= '0;
         base_q <= '0;
         wr_en  <= 1'b0;
         wr_fin <= 1'b0;
      end else begin
         wr_en  <= out_valid;
         wr_fin <= out_valid && end_c;
         if (go) begin
            i_q    <= '0;
            p_q    <= '0;
            s_q    <= '0;
            base_q <= base;
         end else if (out_valid) begin
            if (i_q == IW'(W-1)) begin
               i_q <= '0;
               if (p_q == PW'(R-1)) begin
                  p_q <= '0;
                  s_q <= (s_q == SW'(SPL-1)) ? '0 : s_q + 1'b1;
               end else begin
                  p_q <= p_q + 1'b1;
               end
            end else begin
               i_q <= i_q + 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (out_valid) begin
         wr_addr <= addr_c;
         wr_data <= out_data;
      end
   end
endmodule

// File: rtl/tiled_transpose.sv
`timescale 1ns/1ps
module tiled_transpose
   import tt_pkg::*;
#(
   parameter int unsigned N     = 1024,
   parameter int unsigned W     = 64,
   parameter int unsigned CORES = 1,
   parameter int unsigned AW    = 20
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [AW-1:0]       src_base,
   input  logic [AW-1:0]       dst_base,
   output logic [CORES-1:0]    rd_en,
   output logic [CORES*AW-1:0] rd_addr,
   input  logic [CORES*W-1:0]  rd_data,
   output logic [CORES-1:0]    wr_en,
   output logic [CORES*AW-1:0] wr_addr,
   output logic [CORES*W-1:0]  wr_data,
   output logic                done
);
   localparam int unsigned R   = N / W;
   localparam int unsigned SPL = R / CORES;
   localparam int unsigned MW  = (N / W) * N;

   if (W < 2 || N % W != 0 || CORES < 1 || R % CORES != 0 || (64'd1 << AW) < 64'(MW))
   begin : g_bad_cfg
      $error("tiled_transpose: illegal parameter combination");
   end

   logic             busy;
   logic             go;
   logic [CORES-1:0] fin;

   assign go = start && !busy;

   for (genvar l = 0; l < int'(CORES); l++) begin : g_lane
      logic          re, rlast, iv_q, il_q, ov, we, wf;
      logic [AW-1:0] ra, wa;
      logic [W-1:0]  od, wd;

      tt_rd_seq #(.W(W), .R(R), .SPL(SPL), .LANE(l), .CORES(CORES), .AW(AW)) u_rd (
         .clk(clk), .rst_n(rst_n), .go(go), .base(src_base),
         .rd_en(re), .rd_addr(ra), .row_last(rlast)
      );

      // Align the row strobes with the one-cycle memory read latency.
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            iv_q <= 1'b0;
            il_q <= 1'b0;
         end else begin
            iv_q <= re;
            il_q <= rlast;
         end
      end

      tt_core #(.W(W)) u_core (
         .clk(clk), .rst_n(rst_n), .in_valid(iv_q), .in_data(rd_data[l*W +: W]),
         .in_last(il_q), .out_valid(ov), .out_data(od)
      );

      tt_wr_seq #(.W(W), .R(R), .SPL(SPL), .LANE(l), .CORES(CORES), .AW(AW)) u_wr (
         .clk(clk), .rst_n(rst_n), .go(go), .base(dst_base),
         .out_valid(ov), .out_data(od),
         .wr_en(we), .wr_addr(wa), .wr_data(wd), .wr_fin(wf)
      );

      assign rd_en[l]             = re;
      assign rd_addr[l*AW +: AW]  = ra;
      assign wr_en[l]             = we;
      assign wr_addr[l*AW +: AW]  = wa;
      assign wr_data[l*W +: W]    = wd;
      assign fin[l]               = wf;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         done <= 1'b0;
      end else begin
         done <= &fin;
         if (&fin)    busy <= 1'b0;
         else if (go) busy <= 1'b1;
      end
   end
endmodule

// File: rtl/tt_sva.sv
`timescale 1ns/1ps
module tt_sva #(
   parameter int unsigned CORES = 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             busy,
   input logic             done,
   input logic [CORES-1:0] rd_en,
   input logic [CORES-1:0] wr_en
);
   assert_first_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> rd_en[0]);

   assert_read_in_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en != '0) |-> busy);

   assert_write_in_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en != '0) |-> busy);

   assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(wr_en[0]));

   assert_lanes_lockstep_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en == {CORES{rd_en[0]}}) && (wr_en == {CORES{wr_en[0]}}));
endmodule

bind tiled_transpose tt_sva #(.CORES(CORES)) u_sva (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
   .rd_en(rd_en), .wr_en(wr_en)
);

// File: tb/tiled_transpose_tb_top.sv
`timescale 1ns/1ps
module tt_harness #(
   parameter int N     = 32,
   parameter int W     = 8,
   parameter int CORES = 1,
   parameter int AW    = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [AW-1:0] src_base,
   input  logic [AW-1:0] dst_base,
   input  int            seed,
   output logic          done,
   output logic          rd_any,
   output logic          wr_any,
   output int            n_chk,
   output int            n_err
);
   localparam int R  = N / W;
   localparam int MW = R * N;
   localparam int T  = MW / CORES;

   logic [CORES-1:0]    rd_en, wr_en;
   logic [CORES*AW-1:0] rd_addr, wr_addr;
   logic [CORES*W-1:0]  rd_data, wr_data;

   tiled_transpose #(.N(N), .W(W), .CORES(CORES), .AW(AW)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .src_base(src_base), .dst_base(dst_base),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .done(done)
   );

   assign rd_any = |rd_en;
   assign wr_any = |wr_en;

   int mbusy = 0, sb = 0, db = 0, sd = 0, scyc = 0, lastw = 0, cyc = 0;
   int rk [CORES];
   int wk [CORES];
   bit wflag [1 << AW];

   initial begin
      n_chk = 0;
      n_err = 0;
   end

   // Memory content is a pure function of word address and seed.
   function automatic logic [W-1:0] pat(input int a, input int s);
      int unsigned h;
      if (s == 0) return (a % 3 == 0) ? '1 : '0;
      h = (32'(a) * 32'd2654435761) ^ (32'(s) * 32'd97 + 32'd13);
      h = h ^ (h >> 13);
      return W'(h >> 5);
   endfunction

   always @(posedge clk) cyc <= cyc + 1;

   always_ff @(posedge clk) begin
      for (int l = 0; l < CORES; l++)
         if (rd_en[l]) rd_data[l*W +: W] <= pat(int'(rd_addr[l*AW +: AW]), sd);
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (start && mbusy == 0) begin
            mbusy = 1; sb = int'(src_base); db = int'(dst_base); sd = seed; scyc = cyc;
            for (int l = 0; l < CORES; l++) begin rk[l] = 0; wk[l] = 0; end
            for (int a = 0; a < (1 << AW); a++) wflag[a] = 1'b0;
         end
         for (int l = 0; l < CORES; l++) begin
            if (rd_en[l]) begin
               int k, j, p, s, c, ea;
               k = rk[l]; j = k % W; p = (k / W) % R; s = k / (W * R); c = s * CORES + l;
               ea = (sb + j * R + p * W * R + c) % (1 << AW);
               n_chk++;
               if (mbusy == 0 || int'(rd_addr[l*AW +: AW]) != ea || k >= T) begin
                  n_err++;
                  $display("FAIL R2 lane %0d read %0d addr %0d expected %0d", l, k,
                           rd_addr[l*AW +: AW], ea);
               end
               rk[l] = k + 1;
            end
            if (wr_en[l]) begin
               int k, i, p, s, c, ea, wa;
               logic [W-1:0] ed, wrd;
               k = wk[l]; i = k % W; p = (k / W) % R; s = k / (W * R); c = s * CORES + l;
               ea = (db + p + c * W * R + i * R) % (1 << AW);
               for (int j = 0; j < W; j++) begin
                  wrd = pat(sb + (p * W + j) * R + c, sd);
                  ed[j] = wrd[i];
               end
               wa = int'(wr_addr[l*AW +: AW]);
               n_chk++;
               if (wa != ea || wr_data[l*W +: W] != ed) begin
                  n_err++;
                  $display("FAIL R3 R4 R5 lane %0d write %0d addr %0d data %0h expected addr %0d data %0h",
                           l, k, wa, wr_data[l*W +: W], ea, ed);
               end
               if (wflag[wa]) begin
                  n_err++;
                  $display("FAIL R4 address %0d written twice: got 2 writes expected 1", wa);
               end
               wflag[wa] = 1'b1;
               if (k == 0 && l == 0) begin
                  n_chk++;
                  if (cyc != scyc + W + 3) begin
                     n_err++;
                     $display("FAIL R6 first write cycle %0d expected %0d", cyc, scyc + W + 3);
                  end
               end
               wk[l] = k + 1;
               lastw = cyc;
            end
         end
         if (done) begin
            int tot_w, tot_r, miss;
            tot_w = 0; tot_r = 0; miss = 0;
            for (int l = 0; l < CORES; l++) begin tot_w += wk[l]; tot_r += rk[l]; end
            for (int a = 0; a < MW; a++) if (!wflag[(db + a) % (1 << AW)]) miss++;
            n_chk += 4;
            if (mbusy == 0 || cyc != lastw + 1) begin
               n_err++;
               $display("FAIL R7 done cycle %0d expected %0d (run active %0d)", cyc, lastw + 1, mbusy);
            end
            if (cyc != scyc + T + W + 3) begin
               n_err++;
               $display("FAIL R6 done cycle %0d expected %0d", cyc, scyc + T + W + 3);
            end
            if (tot_w != MW || tot_r != MW) begin
               n_err++;
               $display("FAIL R4 writes %0d reads %0d expected %0d each", tot_w, tot_r, MW);
            end
            if (miss != 0) begin
               n_err++;
               $display("FAIL R4 unwritten output words %0d expected 0", miss);
            end
            mbusy = 0;
         end
      end
   end
endmodule

module tiled_transpose_tb_top;
   localparam int N = 32, W = 8, AW = 9;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          s_start = 1'b0, d_start = 1'b0;
   logic [AW-1:0] src_base = '0, dst_base = '0;
   int            seed = 1;
   logic          s_done, s_rd, s_wr, d_done, d_rd, d_wr;
   int            s_chk, s_err, d_chk, d_err;
   int            n_chk = 0, n_err = 0;

   always #2.5 clk = ~clk;

   tt_harness #(.N(N), .W(W), .CORES(1), .AW(AW)) h_single (
      .clk(clk), .rst_n(rst_n), .start(s_start), .src_base(src_base), .dst_base(dst_base),
      .seed(seed), .done(s_done), .rd_any(s_rd), .wr_any(s_wr), .n_chk(s_chk), .n_err(s_err)
   );

   tt_harness #(.N(N), .W(W), .CORES(2), .AW(AW)) h_dual (
      .clk(clk), .rst_n(rst_n), .start(d_start), .src_base(src_base), .dst_base(dst_base),
      .seed(seed), .done(d_done), .rd_any(d_rd), .wr_any(d_wr), .n_chk(d_chk), .n_err(d_err)
   );

   task automatic report();
      $display("CHECKS %0d ERRORS %0d", n_chk + s_chk + d_chk, n_err + s_err + d_err);
      $finish;
   endtask

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_done(input bit dual);
      int guard = 0;
      forever begin
         @(negedge clk);
         if (dual ? d_done : s_done) break;
         guard++;
         if (guard > 4000) begin
            n_err++;
            $display("FAIL watchdog R7 done actual 0 expected 1");
            report();
         end
      end
      @(negedge clk);
      chk(!(dual ? d_done : s_done), "R7 done low one cycle later", 1, 0);
      chk(!(dual ? (d_rd | d_wr) : (s_rd | s_wr)), "R6 idle after done", 1, 0);
   endtask

   task automatic pulse(input bit dual);
      @(posedge clk); #1;
      if (dual) d_start = 1'b1; else s_start = 1'b1;
      @(posedge clk); #1;
      d_start = 1'b0; s_start = 1'b0;
   endtask

   // R1: outputs idle during and right after reset.
   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(!(s_done | s_rd | s_wr | d_done | d_rd | d_wr), "R1 idle in reset", 1, 0);
      @(posedge clk); #1; rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!(s_done | s_rd | s_wr | d_done | d_rd | d_wr), "R1 idle after reset", 1, 0);
   endtask

   // R2 R3 R4 R5 R6 R7: one full matrix; harness checks every read and write.
   task automatic t_run(input bit dual, input int sb, input int db, input int sd);
      int e0;
      e0 = dual ? d_err : s_err;
      src_base = AW'(sb); dst_base = AW'(db); seed = sd;
      pulse(dual);
      wait_done(dual);
      chk((dual ? d_err : s_err) == e0, "R3 run mismatches", (dual ? d_err : s_err) - e0, 0);
   endtask

   // R8 R9: start pulses and base changes during a run have no effect.
   task automatic t_busy_start(input bit dual);
      int e0;
      e0 = dual ? d_err : s_err;
      src_base = AW'(11); dst_base = AW'(200); seed = 4;
      pulse(dual);
      repeat (30) @(posedge clk);
      #1; src_base = AW'(90); dst_base = AW'(5); seed = 7;
      pulse(dual);
      repeat (40) @(posedge clk);
      #1; src_base = AW'(300);
      pulse(dual);
      wait_done(dual);
      chk((dual ? d_err : s_err) == e0, "R8 R9 mid-run start mismatches",
          (dual ? d_err : s_err) - e0, 0);
   endtask

   initial begin
      t_reset();
      t_run(1'b0, 0, 0, 1);
      t_run(1'b0, 37, 300, 2);
      t_run(1'b0, 0, 128, 0);
      t_busy_start(1'b0);
      t_run(1'b1, 0, 0, 3);      // R10: two lanes on alternate strips
      t_run(1'b1, 130, 260, 5);  // R10 with non-zero bases
      t_busy_start(1'b1);
      repeat (5) @(posedge clk);
      report();
   end
endmodule